// File: doc/BRIEF.md
# Filtered Edge-Triggered Input Capture

This block records the moment an edge arrives on an external capture pin. The pin first crosses into the system clock domain through a two-flop synchronizer. An optional persistence filter can follow it: the filtered level moves only once the synchronized pin has held a new level for four samples in a row. The selected level feeds an edge detector whose polarity is programmable. When a qualifying edge is seen, the block copies the 16-bit count presented on its counter input into a capture register and sets a capture flag. An interrupt request follows the flag while the interrupt enable is high.

The free-running counter is supplied from outside. A capture-disable input stops every capture and flag update. It is meant for the case where the capture register is acting as the counter's TOP value. A one-cycle clear strobe drops the flag. After reset the pin level is taken as low, so the pin should be low when reset is released.

Top module: `icap_unit`

## Requirements
- R1: With the filter enabled, the filtered level changes only after four consecutive synchronized samples show the new level. A pulse lasting three clock cycles is ignored, and a pulse lasting four cycles passes.
- R2: With the filter enabled, a capture takes place four clock cycles later than on the unfiltered path. A pin change that is set up before clock edge k loads the count that was present at edge k+6.
- R3: With edge select 0, only falling edges of the selected level trigger a capture. With edge select 1, only rising edges trigger a capture.
- R4: With the filter disabled, the synchronized pin drives the edge detector directly. A triggering pin change that is set up before clock edge k copies the counter input sampled at edge k+2 into the capture register.
- R5: A capture sets the capture flag. The interrupt output equals the flag AND the interrupt enable.
- R6: While the capture-disable input is 1, neither the capture register nor the flag is updated by an edge.
- R7: A one-cycle clear strobe with no capture in the same cycle drops the flag to 0 on the next clock edge.
- R8: When a capture and a clear strobe occur in the same cycle, the flag ends up 1.
- R9: Changing the edge select while the pin is steady produces no capture.
- R10: After reset the capture register is 0, the flag is 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W (16) | Value of the free-running counter |
| filt_en_i | input | 1 | 1 enables the four-sample persistence filter |
| edge_rise_i | input | 1 | Edge select: 0 for a falling edge, 1 for a rising edge |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle strobe that clears the capture flag |
| cap_block_i | input | 1 | 1 disables capture (capture register acting as TOP) |
| cap_value_o | output | CNT_W (16) | Capture register |
| cap_flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the checker verifies the following:
- A detected edge loads the count and sets the flag, unless capture is disabled.
- The register holds when there is no edge.
- The filter output moves only after four agreeing samples.
- A detected edge has the selected polarity.
- Capture wins over a same-cycle clear.
- The interrupt output follows the flag and the enable.

Only the bench scenarios can show the end-to-end timing from the pin to the register: the exact two-cycle and six-cycle latencies measured against a running count. The same holds for the three-cycle and four-cycle pulse boundary of the filter. They also show that a change of edge select, or a blocked edge, leaves the outputs untouched.

// File: rtl/icap_pkg.sv
package icap_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_pol_e;

   localparam int unsigned SYNC_STAGES_DEF = 2;
   localparam int unsigned FILT_LEN_DEF    = 4;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("icap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned HIST_W = LEN - 1;

   if (LEN < 2) begin : g_bad_len
      $error("icap_filter: LEN must be at least 2");
   end

   logic [HIST_W-1:0] hist_q;
   logic              agree;
   logic              lvl_q;

   if (HIST_W == 1) begin : g_hist_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= d_i;
      end
   end else begin : g_hist_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= {hist_q[HIST_W-2:0], d_i};
      end
   end

   assign agree = (hist_q == {HIST_W{d_i}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lvl_q <= 1'b0;
      else if (agree) lvl_q <= d_i;
   end

   assign q_o = lvl_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
   import icap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl_i,
   input  edge_pol_e pol_i,
   output logic      hit_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   always_comb begin
      unique case (pol_i)
         EDGE_RISE: hit_o = lvl_i & ~prev_q;
         default:   hit_o = ~lvl_i & prev_q;
      endcase
   end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
   parameter int unsigned FILT_LEN    = FILT_LEN_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             filt_en_i,
   input  logic             edge_rise_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   input  logic             cap_block_i,
   output logic [CNT_W-1:0] cap_value_o,
   output logic             cap_flag_o,
   output logic             irq_o
);
   if (CNT_W < 1) begin : g_bad_width
      $error("icap_unit: CNT_W must be at least 1");
   end

   logic sync_lvl;
   logic filt_lvl;
   logic det_lvl;
   logic edge_hit;
   logic cap_evt;

   logic [CNT_W-1:0] value_q;
   logic             flag_q;

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (sync_lvl)
   );

   icap_filter #(.LEN(FILT_LEN)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sync_lvl),
      .q_o   (filt_lvl)
   );

   assign det_lvl = filt_en_i ? filt_lvl : sync_lvl;

   icap_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (det_lvl),
      .pol_i (edge_pol_e'(edge_rise_i)),
      .hit_o (edge_hit)
   );

   assign cap_evt = edge_hit & ~cap_block_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       value_q <= '0;
      else if (cap_evt) value_q <= count_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (cap_evt)    flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign cap_value_o = value_q;
   assign cap_flag_o  = flag_q;
   assign irq_o       = flag_q & irq_en_i;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned FILT_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic             edge_rise_i,
   input logic             irq_en_i,
   input logic             flag_clr_i,
   input logic             cap_block_i,
   input logic [CNT_W-1:0] cap_value_o,
   input logic             cap_flag_o,
   input logic             irq_o,
   input logic             sync_lvl,
   input logic             filt_lvl,
   input logic             det_lvl,
   input logic             edge_hit
);
   logic [2:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age_q <= '0;
      else if (age_q != 3'd7) age_q <= age_q + 3'd1;
   end

   if (FILT_LEN == 4) begin : g_filt_chk
      AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 3'd5 && $changed(filt_lvl)) |->
            ($past(sync_lvl, 1) == filt_lvl && $past(sync_lvl, 2) == filt_lvl &&
             $past(sync_lvl, 3) == filt_lvl && $past(sync_lvl, 4) == filt_lvl)); // R1
   end

   AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |-> (det_lvl == edge_rise_i)); // R3

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit && !cap_block_i) |=> (cap_value_o == $past(count_i)) && cap_flag_o); // R4

   AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_hit |=> $stable(cap_value_o)); // R4

   AST_BLOCK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_block_i |=> $stable(cap_value_o)); // R6

   AST_BLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_block_i && !cap_flag_o) |=> !cap_flag_o); // R6

   AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |-> !irq_o); // R5

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag_o && irq_en_i) |-> irq_o); // R5

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !(edge_hit && !cap_block_i)) |=> !cap_flag_o); // R7

   AST_CAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && edge_hit && !cap_block_i) |=> cap_flag_o); // R8
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .count_i     (count_i),
   .edge_rise_i (edge_rise_i),
   .irq_en_i    (irq_en_i),
   .flag_clr_i  (flag_clr_i),
   .cap_block_i (cap_block_i),
   .cap_value_o (cap_value_o),
   .cap_flag_o  (cap_flag_o),
   .irq_o       (irq_o),
   .sync_lvl    (sync_lvl),
   .filt_lvl    (filt_lvl),
   .det_lvl     (det_lvl),
   .edge_hit    (edge_hit)
);

// File: tb/icap_unit_tb_top.sv
module icap_unit_tb_top;
   localparam int unsigned CNT_W = 16;
   localparam int unsigned LAT_RAW  = 2;
   localparam int unsigned LAT_FILT = 6;

   // vector fields: filt, rise, blk, lvl, ien
   typedef struct packed {
      logic filt;
      logic rise;
      logic blk;
      logic lvl;
      logic ien;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      5'b0_1_0_1_1,  // rising, rise select: capture (R4)
      5'b0_1_0_0_0,  // falling, rise select: none (R3)
      5'b0_0_0_1_1,  // rising, fall select: none (R3)
      5'b0_0_0_0_1,  // falling, fall select: capture (R3)
      5'b1_1_0_1_0,  // filtered rising: capture (R2)
      5'b1_0_0_0_1,  // filtered falling: capture (R2)
      5'b0_1_1_1_1,  // blocked rising (R6)
      5'b0_0_0_1_1,  // select change, pin steady (R9)
      5'b0_1_0_1_1,  // select change back, pin steady (R9)
      5'b1_0_1_0_0,  // filtered blocked falling (R6)
      5'b1_1_0_1_1   // filtered rising: capture (R2)
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin_i = 1'b0;
   logic [CNT_W-1:0] cyc = '0;
   logic             filt_en_i = 1'b0;
   logic             edge_rise_i = 1'b0;
   logic             irq_en_i = 1'b0;
   logic             flag_clr_i = 1'b0;
   logic             cap_block_i = 1'b0;
   logic [CNT_W-1:0] cap_value_o;
   logic             cap_flag_o;
   logic             irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [CNT_W-1:0] exp_val = '0;
   logic             prev_lvl = 1'b0;

   always #10 clk = ~clk;

   always_ff @(posedge clk) cyc <= cyc + 1'b1;

   icap_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin_i),
      .count_i     (cyc),
      .filt_en_i   (filt_en_i),
      .edge_rise_i (edge_rise_i),
      .irq_en_i    (irq_en_i),
      .flag_clr_i  (flag_clr_i),
      .cap_block_i (cap_block_i),
      .cap_value_o (cap_value_o),
      .cap_flag_o  (cap_flag_o),
      .irq_o       (irq_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_flag();
      @(negedge clk) flag_clr_i = 1'b1;
      @(negedge clk) flag_clr_i = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // low-going pulse of given width from a high pin, falling edge selected
   task automatic pulse(input logic filt, input int width, input string req,
                        input logic exp_cap);
      logic [CNT_W-1:0] n0;
      clear_flag();
      @(negedge clk);
      filt_en_i = filt; edge_rise_i = 1'b0; cap_block_i = 1'b0;
      pin_i = 1'b0;
      n0 = cyc;
      wait_cyc(width);
      pin_i = 1'b1;
      wait_cyc(10);
      if (exp_cap) exp_val = n0 + (filt ? CNT_W'(LAT_FILT) : CNT_W'(LAT_RAW));
      chk(req, "pulse flag", 32'(cap_flag_o), 32'(exp_cap));
      chk(req, "pulse value", 32'(cap_value_o), 32'(exp_val));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CNT_W-1:0] n0;
      logic cap;
      string tag;

      wait_cyc(3);
      // R10: reset state
      chk("R10", "value", 32'(cap_value_o), 32'h0);
      chk("R10", "flag", 32'(cap_flag_o), 32'h0);
      chk("R10", "irq", 32'(irq_o), 32'h0);
      @(negedge clk) rst_n = 1'b1;
      wait_cyc(6);

      for (int i = 0; i < NVEC; i++) begin
         clear_flag();
         @(negedge clk);
         filt_en_i   = VECS[i].filt;
         edge_rise_i = VECS[i].rise;
         cap_block_i = VECS[i].blk;
         irq_en_i    = VECS[i].ien;
         pin_i       = VECS[i].lvl;
         n0 = cyc;
         cap = !VECS[i].blk &&
               (VECS[i].rise ? (!prev_lvl && VECS[i].lvl) : (prev_lvl && !VECS[i].lvl));
         if (cap) exp_val = n0 + (VECS[i].filt ? CNT_W'(LAT_FILT) : CNT_W'(LAT_RAW));
         if (VECS[i].blk)             tag = "R6";
         else if (prev_lvl == VECS[i].lvl) tag = "R9";
         else if (!cap)               tag = "R3";
         else if (VECS[i].filt)       tag = "R2";
         else                         tag = "R4";
         prev_lvl = VECS[i].lvl;
         wait_cyc(8);
         chk(tag, $sformatf("vec %0d flag", i), 32'(cap_flag_o), 32'(cap));
         chk(tag, $sformatf("vec %0d value", i), 32'(cap_value_o), 32'(exp_val));
         chk("R5", $sformatf("vec %0d irq", i), 32'(irq_o), 32'(cap & VECS[i].ien));
      end

      // R7: clear strobe drops flag set by last vector
      chk("R7", "flag before clear", 32'(cap_flag_o), 32'h1);
      clear_flag();
      wait_cyc(1);
      chk("R7", "flag after clear", 32'(cap_flag_o), 32'h0);
      chk("R7", "irq after clear", 32'(irq_o), 32'h0);

      // R1: filter pulse boundary, R4: unfiltered short pulse
      pulse(1'b1, 3, "R1", 1'b0);
      pulse(1'b1, 4, "R1", 1'b1);
      pulse(1'b0, 3, "R4", 1'b1);

      // R8: capture and clear in the same cycle
      clear_flag();
      @(negedge clk);
      filt_en_i = 1'b0; edge_rise_i = 1'b0; cap_block_i = 1'b0; irq_en_i = 1'b1;
      pin_i = 1'b0;
      n0 = cyc;
      wait_cyc(2);
      flag_clr_i = 1'b1;   // active during the capture edge k+2
      @(negedge clk) flag_clr_i = 1'b0;
      wait_cyc(2);
      exp_val = n0 + CNT_W'(LAT_RAW);
      chk("R8", "flag after clear+capture", 32'(cap_flag_o), 32'h1);
      chk("R8", "value", 32'(cap_value_o), 32'(exp_val));
      chk("R5", "irq enabled", 32'(irq_o), 32'h1);
      @(negedge clk) irq_en_i = 1'b0;
      wait_cyc(1);
      chk("R5", "irq masked", 32'(irq_o), 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule